// File: doc/BRIEF.md
# Audio Master-Clock Ratio Manager

This block sits in the master-clock domain of an audio converter. It takes the frame clock, which has one period per sample, and counts master-clock cycles between its rising edges. From that count it works out whether the master clock runs at 256, 384 or 512 times the sample rate. Once two frames in a row agree, it declares the clocks valid. It then produces a clock enable that fires 256 times per frame whatever the incoming ratio is, so the logic downstream always sees the same internal rate.

The frame clock may arrive with any phase relative to the master clock, so it passes through a two-flop synchroniser before its edges are detected. The converter is held in power-down while the run request input is low. It is also held there whenever the clocks are not valid: after reset, after a frame period that does not match any supported ratio, and after the frame clock stops. The ratio found is reported as a two-bit code together with a clocks-valid flag.

Top module: `clk_ratio_mgr`

## Requirements
- R1: While reset is asserted and right after it is released, clocksValid is 0, ratioCode is 0, powerDown is 1 and ce256 is 0.
- R2: The frame period is the number of master-clock cycles between two consecutive rising edges of lrckIn. A period of 255 to 257 gives ratioCode 1, a period of 383 to 385 gives ratioCode 2, and a period of 511 to 513 gives ratioCode 3.
- R3: A frame period outside these three windows (for example 300 or 386) leaves clocksValid at 0 and ratioCode at 0.
- R4: powerDown is 1 whenever runReq is 0, even when the clocks are valid. powerDown is 0 only when runReq is 1 and clocksValid is 1. ce256 and the ratio detection keep running while runReq is 0.
- R5: The first rising edge of lrckIn after reset is not measured. clocksValid becomes 1 only after two consecutive measured frames give the same nonzero ratio code, so three rising edges are needed after reset.
- R6: If lrckIn shows no rising edge for 1024 master-clock cycles, clocksValid and ratioCode return to 0. A gap of fewer than 900 cycles leaves them unchanged.
- R7: ce256 is 0 in every cycle in which clocksValid is 0.
- R8: With ratioCode 1, ce256 is 1 in every cycle, so a frame of N cycles holds N enables.
- R9: With ratioCode 3, ce256 alternates high and low. The cycle after each frame edge is high, so an exact 512-cycle frame holds 256 enables.
- R10: With ratioCode 2, ce256 follows the pattern high, high, low, and the pattern restarts after each frame edge. An exact 384-cycle frame holds 256 enables, and ce256 is never low in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| lrckIn | input | 1 | Frame clock, synchronous in rate but arbitrary in phase |
| runReq | input | 1 | Run request; low forces power-down |
| ce256 | output | 1 | Clock enable at 256 times the frame rate |
| powerDown | output | 1 | High while the converter must stay powered down |
| ratioCode | output | 2 | 0 none, 1 = 256x, 2 = 384x, 3 = 512x |
| clocksValid | output | 1 | Ratio locked on two matching frames |

## Verification
The collision that matters is the frame-edge restart of the enable phase landing in the same cycle as the phase counter's own wrap, or just before it. It is provoked by running off-by-one frame lengths (255, 383, 513) next to the exact ones. The bench counts enables over a full frame and records the longest run of low cycles, and both must match the values the pattern rule gives. A second collision is between re-lock and an outgoing stream: the bench switches frame lengths without a reset, and the new ratio must appear only after two matching frames while a bad length drops the lock.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_256  = 2'd1,
    RATIO_384  = 2'd2,
    RATIO_512  = 2'd3
  } ratio_e;

  // strobes from control to the enable datapath
  typedef struct packed {
    logic   frameStart;
    logic   locked;
    ratio_e ratio;
  } ctrl_strobe_t;

endpackage

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int BASE_RATIO  = 256,
  parameter int TOLERANCE   = 1,
  parameter int TIMEOUT     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameClk,
  output ctrl_strobe_t strobes
);

  localparam int CNT_W   = $clog2(TIMEOUT);
  localparam int CNT_MAX = TIMEOUT - 1;
  localparam int LEN_256 = BASE_RATIO;
  localparam int LEN_384 = (BASE_RATIO * 3) / 2;
  localparam int LEN_512 = BASE_RATIO * 2;

  // synchroniser plus one delay stage for edge detection
  logic [SYNC_STAGES:0] syncQ;
  logic                 rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], frameClk};
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   periodLen;
  logic             havePrev;
  logic             locked;
  ratio_e           prevClass;
  ratio_e           measClass;
  ratio_e           lockedRatio;

  function automatic logic inWindow(input int len, input int centre);
    return (len >= centre - TOLERANCE) && (len <= centre + TOLERANCE);
  endfunction

  assign periodLen = {1'b0, cnt} + 1'b1;

  always_comb begin
    int len;
    len = int'(periodLen);
    if (inWindow(len, LEN_256))      measClass = RATIO_256;
    else if (inWindow(len, LEN_384)) measClass = RATIO_384;
    else if (inWindow(len, LEN_512)) measClass = RATIO_512;
    else                             measClass = RATIO_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      havePrev    <= 1'b0;
      locked      <= 1'b0;
      prevClass   <= RATIO_NONE;
      lockedRatio <= RATIO_NONE;
    end else if (rise) begin
      cnt      <= '0;
      havePrev <= 1'b1;
      if (havePrev) begin
        prevClass <= measClass;
        if (measClass != RATIO_NONE && measClass == prevClass) begin
          locked      <= 1'b1;
          lockedRatio <= measClass;
        end else begin
          locked      <= 1'b0;
          lockedRatio <= RATIO_NONE;
        end
      end
    end else if (cnt == CNT_W'(CNT_MAX)) begin
      havePrev    <= 1'b0;
      locked      <= 1'b0;
      prevClass   <= RATIO_NONE;
      lockedRatio <= RATIO_NONE;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign strobes.frameStart = rise;
  assign strobes.locked     = locked;
  assign strobes.ratio      = lockedRatio;

  // a lock always carries a real ratio
  assert_lock_has_ratio_R2: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> lockedRatio != RATIO_NONE);

  // lock appears only on a measured frame edge
  assert_lock_on_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> ($past(rise) && $past(havePrev)));

  // a stalled frame clock removes the lock
  assert_stall_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_W'(CNT_MAX) && !rise) |=> !locked);

endmodule

// File: rtl/ce_gen.sv
module ce_gen
  import clk_ratio_pkg::*;
#(
  parameter int PHASE_W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobes,
  output logic         ce
);

  localparam logic [PHASE_W-1:0] THIRD_LAST = PHASE_W'(2);

  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (strobes.frameStart) begin
      phase <= '0;
    end else begin
      unique case (strobes.ratio)
        RATIO_384: phase <= (phase == THIRD_LAST) ? '0 : phase + 1'b1;
        RATIO_512: phase <= {{(PHASE_W-1){1'b0}}, ~phase[0]};
        default:   phase <= '0;
      endcase
    end
  end

  always_comb begin
    ce = 1'b0;
    if (strobes.locked) begin
      unique case (strobes.ratio)
        RATIO_256: ce = 1'b1;
        RATIO_384: ce = (phase != THIRD_LAST);
        RATIO_512: ce = (phase == '0);
        default:   ce = 1'b0;
      endcase
    end
  end

  // half rate toggles every cycle away from frame edges
  assert_half_rate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.locked && strobes.ratio == RATIO_512 && $past(strobes.locked)
     && $past(strobes.ratio) == RATIO_512 && !$past(strobes.frameStart))
    |-> (ce != $past(ce)));

  // two-of-three pattern never idles twice in a row
  assert_single_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.locked && strobes.ratio == RATIO_384 && !ce)
    |=> (ce || !strobes.locked));

endmodule

// File: rtl/clk_ratio_mgr.sv
module clk_ratio_mgr
  import clk_ratio_pkg::*;
#(
  parameter int BASE_RATIO  = 256,
  parameter int TOLERANCE   = 1,
  parameter int TIMEOUT     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       lrckIn,
  input  logic       runReq,
  output logic       ce256,
  output logic       powerDown,
  output logic [1:0] ratioCode,
  output logic       clocksValid
);

  ctrl_strobe_t strobes;

  ratio_ctrl #(
    .BASE_RATIO (BASE_RATIO),
    .TOLERANCE  (TOLERANCE),
    .TIMEOUT    (TIMEOUT),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk     (mclk),
    .rstN    (rstN),
    .frameClk(lrckIn),
    .strobes (strobes)
  );

  ce_gen #(.PHASE_W(2)) i_ce (
    .clk    (mclk),
    .rstN   (rstN),
    .strobes(strobes),
    .ce     (ce256)
  );

  assign clocksValid = strobes.locked;
  assign ratioCode   = strobes.ratio;
  assign powerDown   = !runReq || !strobes.locked;

  // no enable leaves the block while the clocks are invalid
  assert_quiet_unlocked_R7: assert property (@(posedge mclk) disable iff (!rstN)
    !clocksValid |-> !ce256);

endmodule

// File: tb/test_clk_ratio_mgr.sv
module test_clk_ratio_mgr;

  logic       mclk = 1'b0;
  logic       rstN = 1'b0;
  logic       lrckIn = 1'b0;
  logic       runReq = 1'b1;
  logic       ce256;
  logic       powerDown;
  logic [1:0] ratioCode;
  logic       clocksValid;

  int checks = 0;
  int failures = 0;
  int ceCnt;
  int maxLow;
  bit finished = 0;

  always #10 mclk = ~mclk;

  clk_ratio_mgr i_clk_ratio_mgr (
    .mclk(mclk), .rstN(rstN), .lrckIn(lrckIn), .runReq(runReq),
    .ce256(ce256), .powerDown(powerDown), .ratioCode(ratioCode),
    .clocksValid(clocksValid)
  );

  // period, ratio code, valid, enables per frame, longest low run
  localparam int VEC_N = 8;
  localparam int vPeriod[VEC_N] = '{256, 384, 512, 255, 513, 383, 300, 386};
  localparam int vRatio [VEC_N] = '{1,   2,   3,   1,   3,   2,   0,   0};
  localparam int vValid [VEC_N] = '{1,   1,   1,   1,   1,   1,   0,   0};
  localparam int vCe    [VEC_N] = '{256, 256, 256, 255, 257, 256, 0,   0};
  localparam int vLow   [VEC_N] = '{0,   1,   1,   0,   1,   1,   300, 386};

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // frames of given length; enable statistics over the last one
  task automatic runFrames(input int period, input int frames);
    int curLow;
    for (int f = 0; f < frames; f++) begin
      if (f == frames - 1) begin
        ceCnt = 0; maxLow = 0; curLow = 0;
      end
      for (int i = 0; i < period; i++) begin
        @(negedge mclk);
        if (f == frames - 1) begin
          if (ce256) begin ceCnt++; curLow = 0; end
          else begin curLow++; if (curLow > maxLow) maxLow = curLow; end
        end
        lrckIn = (i < period / 2);
      end
    end
  endtask

  task automatic holdLow(input int cycles);
    ceCnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge mclk);
      if (ce256) ceCnt++;
      lrckIn = 1'b0;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge mclk);
    checkEq("R1", "valid in reset", clocksValid, 0);
    rstN = 1'b1;
    @(negedge mclk);
    checkEq("R1", "valid", clocksValid, 0);
    checkEq("R1", "ratio", ratioCode, 0);
    checkEq("R1", "powerDown", powerDown, 1);
    checkEq("R1", "ce", ce256, 0);

    // R5 two edges are not enough, the third locks
    runFrames(384, 2);
    checkEq("R5", "valid after two edges", clocksValid, 0);
    runFrames(384, 1);
    checkEq("R5", "valid after three edges", clocksValid, 1);
    checkEq("R5", "ratio after lock", ratioCode, 2);

    // R2 R3 R7 R8 R9 R10 vector table
    for (int v = 0; v < VEC_N; v++) begin
      runFrames(vPeriod[v], 6);
      $display("vector period=%0d", vPeriod[v]);
      checkEq("R2/R3", "ratio", ratioCode, vRatio[v]);
      checkEq("R2/R3", "valid", clocksValid, vValid[v]);
      checkEq("R4", "powerDown", powerDown, 1 - vValid[v]);
      checkEq("R7/R8/R9/R10", "enables per frame", ceCnt, vCe[v]);
      checkEq("R10", "longest low run", maxLow, vLow[v]);
    end

    // R4 run request low forces power-down while locked
    runFrames(256, 6);
    runReq = 1'b0;
    runFrames(256, 2);
    checkEq("R4", "powerDown forced", powerDown, 1);
    checkEq("R4", "valid kept", clocksValid, 1);
    checkEq("R4", "ratio kept", ratioCode, 1);
    checkEq("R4", "enables keep running", ceCnt, 256);
    runReq = 1'b1;
    @(negedge mclk);
    checkEq("R4", "powerDown released", powerDown, 0);

    // R6 short gap keeps lock, long gap drops it
    runFrames(256, 3);
    holdLow(600);
    checkEq("R6", "valid after short gap", clocksValid, 1);
    holdLow(500);
    checkEq("R6", "valid after stall", clocksValid, 0);
    checkEq("R6", "ratio after stall", ratioCode, 0);
    checkEq("R6", "powerDown after stall", powerDown, 1);
    holdLow(50);
    checkEq("R7", "no enables after stall", ceCnt, 0);
    runFrames(512, 5);
    checkEq("R6", "relock after stall", ratioCode, 3);

    finish();
  end

endmodule